// File: doc/BRIEF.md
# PWM Controller Register File

This block is the byte-wide register map that sits in front of a multi-channel pulse-width generator. A serial slave (or any other bus agent) presents an 8-bit address with a one-cycle write strobe or read strobe. The block holds the two mode bytes, four compare bytes per channel, a four-byte broadcast window that loads every channel at once, and a clock prescale byte. Its outputs drive the generator directly: the per-channel 12-bit turn-on and turn-off counts, the per-channel forced-on and forced-off flags, the prescale value, and the sleep, polarity and drive-style controls.

Two rules are enforced in hardware. The prescale byte accepts a new value only while the device is asleep. After sleep is released, the oscillator-running indication stays low for a programmable number of clock cycles, which models the oscillator start-up interval. With a 100 MHz clock a 500 µs interval corresponds to 50 000 cycles.

Read data is registered. It appears on `rdata` in the cycle after the read strobe and holds there until the next read.

Top module: `pwm_regfile`

## Requirements
- R1: After reset, address 0x00 reads 0x10 (sleep set), address 0x01 reads 0x04 (totem-pole drive, no inversion), address 0xFE reads 0x1E, every channel has both its forced-on and forced-off flags set with zero counts, and `osc_run` is low.
- R2: Channel N (0 to NCH-1) occupies addresses 0x06+4N to 0x09+4N, in the order turn-on low byte, turn-on high byte, turn-off low byte, turn-off high byte. A write updates only the addressed byte, and the byte reads back at the same address.
- R3: In each high byte, bits 3:0 carry count bits 11:8 and bit 4 carries the forced flag (forced-on for the turn-on byte, forced-off for the turn-off byte). Bits 7:5 ignore writes and read as zero.
- R4: A write to 0xFA, 0xFB, 0xFC or 0xFD updates the turn-on low, turn-on high, turn-off low or turn-off high byte, respectively, of every channel in the same cycle. A read of 0xFA to 0xFD returns 0x00.
- R5: A write to 0xFE while bit 4 of address 0x00 (sleep) is set loads the `prescale` output and the readback value.
- R6: A write to 0xFE while sleep is clear is ignored, and the old prescale value is kept.
- R7: When sleep goes from 1 to 0, `osc_run` rises exactly WAKE_CYCLES clock edges after the edge that captured the write. Setting sleep again drops `osc_run` at the edge that captures that write.
- R8: Bit 4 of address 0x01 drives `invert` and bit 2 drives `totem`.
- R9: `rdata` updates only on a read strobe and is valid in the cycle that follows it. A read of any address that is not a mode, channel, broadcast or prescale address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| on_cnt | output | NCH*12 | Turn-on counts, channel N at bits [12N+11:12N] |
| off_cnt | output | NCH*12 | Turn-off counts, same packing |
| full_on | output | NCH | Forced-on flag per channel |
| full_off | output | NCH | Forced-off flag per channel |
| prescale | output | 8 | Active prescale value |
| sleep | output | 1 | Sleep control (mode byte 0, bit 4) |
| invert | output | 1 | Output polarity inversion |
| totem | output | 1 | 1 = totem-pole drive, 0 = open-drain drive |
| osc_run | output | 1 | Oscillator is running and settled |

## Verification
A vector table writes channel bytes with unused high bits set. This separates correct field masking from plain storage. The same table writes the first and the last channel, which exposes offset errors in the channel decoder. It also reads mode, prescale and unmapped addresses, which separates the read-mux arms. A pair of broadcast writes is then compared against every channel's output ports. This distinguishes true fan-out from a write that lands on one channel only. Directed sequences release sleep and check `osc_run` one cycle before and exactly at the end of the wake window. They also write the prescale byte while awake, which separates the sleep gate from an ungated register.

// File: rtl/pwm_regfile_pkg.sv
package pwm_regfile_pkg;

  localparam logic [7:0] A_MODE1    = 8'h00;
  localparam logic [7:0] A_MODE2    = 8'h01;
  localparam logic [7:0] A_CH_BASE  = 8'h06;
  localparam logic [7:0] A_BC_BASE  = 8'hFA;
  localparam logic [7:0] A_PRESCALE = 8'hFE;

  localparam int SLEEP_BIT = 4;
  localparam int FLAG_BIT  = 4;
  localparam int INV_BIT   = 4;
  localparam int DRV_BIT   = 2;

  localparam logic [7:0] MODE1_RST    = 8'h10;
  localparam logic [7:0] MODE2_RST    = 8'h04;
  localparam logic [7:0] PRESCALE_RST = 8'h1E;

  // byte position inside one channel's four-byte group
  typedef enum logic [1:0] {
    SEL_ON_LO  = 2'd0,
    SEL_ON_HI  = 2'd1,
    SEL_OFF_LO = 2'd2,
    SEL_OFF_HI = 2'd3
  } byte_sel_e;

  function automatic logic is_chan(input logic [7:0] a, input int nch);
    return (int'(a) >= int'(A_CH_BASE)) && (int'(a) < int'(A_CH_BASE) + 4 * nch);
  endfunction

  function automatic logic is_bcast(input logic [7:0] a);
    return (a >= A_BC_BASE) && (a <= A_BC_BASE + 8'd3);
  endfunction

  function automatic logic [7:0] chan_ofs(input logic [7:0] a);
    return a - A_CH_BASE;
  endfunction

  function automatic logic [7:0] bcast_ofs(input logic [7:0] a);
    return a - A_BC_BASE;
  endfunction

  // compose a high byte: upper count bits low, flag at FLAG_BIT, rest zero
  function automatic logic [7:0] hi_byte(input logic [3:0] cnt_hi, input logic flag);
    logic [7:0] b;
    b = 8'h00;
    b[3:0] = cnt_hi;
    b[FLAG_BIT] = flag;
    return b;
  endfunction

endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
  import pwm_regfile_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  byte_sel_e        sel,
  input  logic [7:0]       wdata,
  output logic [CNT_W-1:0] on_cnt,
  output logic [CNT_W-1:0] off_cnt,
  output logic             on_full,
  output logic             off_full,
  output logic [7:0]       rbyte
);
  localparam int HI_W = CNT_W - 8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_cnt   <= '0;
      off_cnt  <= '0;
      on_full  <= 1'b1;
      off_full <= 1'b1;
    end else if (we) begin
      case (sel)
        SEL_ON_LO:  on_cnt[7:0] <= wdata;
        SEL_ON_HI: begin
          on_cnt[CNT_W-1:8] <= wdata[HI_W-1:0];
          on_full           <= wdata[FLAG_BIT];
        end
        SEL_OFF_LO: off_cnt[7:0] <= wdata;
        default: begin
          off_cnt[CNT_W-1:8] <= wdata[HI_W-1:0];
          off_full           <= wdata[FLAG_BIT];
        end
      endcase
    end
  end

  logic [3:0] on_hi4, off_hi4;
  always_comb begin
    on_hi4  = '0;
    off_hi4 = '0;
    on_hi4[HI_W-1:0]  = on_cnt[CNT_W-1:8];
    off_hi4[HI_W-1:0] = off_cnt[CNT_W-1:8];
    case (sel)
      SEL_ON_LO:  rbyte = on_cnt[7:0];
      SEL_ON_HI:  rbyte = hi_byte(on_hi4, on_full);
      SEL_OFF_LO: rbyte = off_cnt[7:0];
      default:    rbyte = hi_byte(off_hi4, off_full);
    endcase
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable({on_cnt, off_cnt, on_full, off_full}));

  // R3
  flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == SEL_OFF_HI) |=> off_full == $past(wdata[FLAG_BIT]));

endmodule

// File: rtl/pwm_mode_regs.sv
module pwm_mode_regs
  import pwm_regfile_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we_mode1,
  input  logic       we_mode2,
  input  logic       we_pre,
  input  logic [7:0] wdata,
  output logic [7:0] mode1,
  output logic [7:0] mode2,
  output logic [7:0] prescale
);
  logic asleep;
  logic pre_load;

  assign asleep   = mode1[SLEEP_BIT];
  assign pre_load = we_pre && asleep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode1    <= MODE1_RST;
      mode2    <= MODE2_RST;
      prescale <= PRESCALE_RST;
    end else begin
      if (we_mode1) mode1    <= wdata;
      if (we_mode2) mode2    <= wdata;
      if (pre_load) prescale <= wdata;
    end
  end

  // R5
  pre_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_pre && asleep) |=> prescale == $past(wdata));

  // R6
  pre_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !asleep |=> $stable(prescale));

endmodule

// File: rtl/pwm_wake_timer.sv
module pwm_wake_timer #(
  parameter int WAKE_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep,
  output logic osc_run
);
  localparam int CW = $clog2(WAKE_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(WAKE_CYCLES);

  logic [CW-1:0] remain;
  logic          settled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               remain <= LOAD;
    else if (sleep)           remain <= LOAD;
    else if (remain != '0)    remain <= remain - 1'b1;
  end

  assign settled = (remain == '0);
  assign osc_run = !sleep && settled;

  // R7
  wake_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep) |-> !osc_run);

  // R7
  wake_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_run) |-> $past(remain) == CW'(1));

endmodule

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_regfile_pkg::*;
#(
  parameter int NCH         = 16,
  parameter int CNT_W       = 12,
  parameter int WAKE_CYCLES = 50000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [7:0]           addr,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata,
  output logic [NCH*CNT_W-1:0] on_cnt,
  output logic [NCH*CNT_W-1:0] off_cnt,
  output logic [NCH-1:0]       full_on,
  output logic [NCH-1:0]       full_off,
  output logic [7:0]           prescale,
  output logic                 sleep,
  output logic                 invert,
  output logic                 totem,
  output logic                 osc_run
);
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

  // address decode, brought out as named events
  logic       hit_chan, hit_bc, hit_m1, hit_m2, hit_pre, hit_none;
  logic [7:0] ofs_ch, ofs_bc;
  logic [IDX_W-1:0] ch_idx;
  byte_sel_e  ch_sel;

  assign hit_chan = is_chan(addr, NCH);
  assign hit_bc   = is_bcast(addr);
  assign hit_m1   = (addr == A_MODE1);
  assign hit_m2   = (addr == A_MODE2);
  assign hit_pre  = (addr == A_PRESCALE);
  assign hit_none = !(hit_chan || hit_bc || hit_m1 || hit_m2 || hit_pre);
  assign ofs_ch   = chan_ofs(addr);
  assign ofs_bc   = bcast_ofs(addr);
  assign ch_idx   = ofs_ch[IDX_W+1:2];
  assign ch_sel   = byte_sel_e'(hit_bc ? ofs_bc[1:0] : ofs_ch[1:0]);

  logic [7:0] mode1, mode2;

  pwm_mode_regs u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_mode1 (wr_en && hit_m1),
    .we_mode2 (wr_en && hit_m2),
    .we_pre   (wr_en && hit_pre),
    .wdata    (wdata),
    .mode1    (mode1),
    .mode2    (mode2),
    .prescale (prescale)
  );

  assign sleep  = mode1[SLEEP_BIT];
  assign invert = mode2[INV_BIT];
  assign totem  = mode2[DRV_BIT];

  pwm_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
    .clk     (clk),
    .rst_n   (rst_n),
    .sleep   (sleep),
    .osc_run (osc_run)
  );

  logic [7:0] ch_rbyte [NCH];

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic ch_we;
    assign ch_we = wr_en && (hit_bc || (hit_chan && ch_idx == IDX_W'(n)));

    pwm_chan_regs #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (ch_we),
      .sel      (ch_sel),
      .wdata    (wdata),
      .on_cnt   (on_cnt[n*CNT_W +: CNT_W]),
      .off_cnt  (off_cnt[n*CNT_W +: CNT_W]),
      .on_full  (full_on[n]),
      .off_full (full_off[n]),
      .rbyte    (ch_rbyte[n])
    );
  end

  logic [7:0] rd_byte;
  always_comb begin
    rd_byte = 8'h00;
    if (hit_m1)        rd_byte = mode1;
    else if (hit_m2)   rd_byte = mode2;
    else if (hit_pre)  rd_byte = prescale;
    else if (hit_chan) rd_byte = ch_rbyte[ch_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= 8'h00;
    else if (rd_en) rdata <= rd_byte;
  end

  // R9
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hit_none) |=> rdata == 8'h00);

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  // R4
  bc_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hit_bc) |=> rdata == 8'h00);

  // R4
  bc_fan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_BC_BASE + 8'd2) |=>
      (off_cnt[(NCH-1)*CNT_W +: 8] == $past(wdata)) && (off_cnt[7:0] == $past(wdata)));

endmodule

// File: tb/pwm_regfile_bench.sv
module pwm_regfile_bench;
  localparam int NCH  = 16;
  localparam int CW   = 12;
  localparam int WAKE = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic [NCH*CW-1:0] on_cnt, off_cnt;
  logic [NCH-1:0] full_on, full_off;
  logic [7:0] prescale;
  logic sleep, invert, totem, osc_run;

  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  pwm_regfile #(.NCH(NCH), .CNT_W(CW), .WAKE_CYCLES(WAKE)) u_pwm_regfile (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .on_cnt(on_cnt), .off_cnt(off_cnt),
    .full_on(full_on), .full_off(full_off), .prescale(prescale),
    .sleep(sleep), .invert(invert), .totem(totem), .osc_run(osc_run)
  );

  // {addr, write data, expected readback}
  localparam int NV = 12;
  localparam logic [23:0] VEC [NV] = '{
    24'h06_34_34,   // R2 ch0 on low
    24'h07_E5_05,   // R3 bits 7:5 dropped, flag 0
    24'h08_FF_FF,   // R2 ch0 off low
    24'h09_1A_1A,   // R3 flag 1, count hi A
    24'h42_77_77,   // R2 ch15 on low
    24'h45_FF_1F,   // R3 ch15 off high
    24'h30_55_55,   // R2 ch10 off low
    24'hFE_79_79,   // R5 prescale while asleep
    24'h01_10_10,   // R8 invert on, open-drain
    24'h03_AA_00,   // R9 unmapped
    24'h50_12_00,   // R9 beyond last channel
    24'hFF_12_00    // R9 top address
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    logic ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, r); chk("R1 mode1", r, 8'h10);
    rd(8'h01, r); chk("R1 mode2", r, 8'h04);
    rd(8'hFE, r); chk("R1 prescale", r, 8'h1E);
    chk("R1 sleep/osc", {sleep, osc_run}, 2'b10);
    chk("R1 full_on", full_on, {NCH{1'b1}});
    chk("R1 full_off", full_off, {NCH{1'b1}});
    chk("R1 counts", {on_cnt[CW-1:0], off_cnt[CW-1:0]}, 0);
    chk("R8 reset drive", {invert, totem}, 2'b01);

    // table walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][23:16], VEC[i][15:8]);
      rd(VEC[i][23:16], r);
      chk($sformatf("R2/R3/R5/R9 vec%0d", i), r, VEC[i][7:0]);
    end

    // R3 fields at the ports
    chk("R3 ch0 on_cnt", on_cnt[CW-1:0], 12'h534);
    chk("R3 ch0 full_on", full_on[0], 1'b0);
    chk("R3 ch0 off_cnt", off_cnt[CW-1:0], 12'hAFF);
    chk("R3 ch0 full_off", full_off[0], 1'b1);
    chk("R2 ch10 untouched on", on_cnt[10*CW +: CW], 12'h000);
    chk("R5 prescale port", prescale, 8'h79);
    chk("R8 invert/totem", {invert, totem}, 2'b10);

    // R4 broadcast
    wr(8'hFC, 8'h21);
    wr(8'hFD, 8'h03);
    ok = 1'b1;
    for (int n = 0; n < NCH; n++)
      if (off_cnt[n*CW +: CW] !== 12'h321) ok = 1'b0;
    chk("R4 all off_cnt", ok, 1'b1);
    chk("R4 all full_off clear", full_off, {NCH{1'b0}});
    chk("R4 on side kept", on_cnt[CW-1:0], 12'h534);
    rd(8'h24, r); chk("R4 ch7 readback", r, 8'h21);
    rd(8'hFC, r); chk("R4 broadcast read", r, 8'h00);

    // R7 wake delay
    wr(8'h00, 8'h00);
    repeat (WAKE - 1) @(negedge clk);
    chk("R7 still waking", osc_run, 1'b0);
    @(negedge clk);
    chk("R7 settled", osc_run, 1'b1);

    // R6 prescale locked while awake
    wr(8'hFE, 8'h55);
    rd(8'hFE, r); chk("R6 prescale readback", r, 8'h79);
    chk("R6 prescale port", prescale, 8'h79);

    // R7 back to sleep
    wr(8'h00, 8'h10);
    chk("R7 sleep drops osc", {sleep, osc_run}, 2'b10);

    finish_run();
  end
endmodule